// File: doc/BRIEF.md
# Serial Strobe Offset Control Register

This block holds the setting that moves a data-detection window early or late with respect to its nominal position. A six-bit word is clocked in serially on an external shift clock, which may be the recovered data pulses themselves. Shifting is allowed while the enable input is low. When the enable goes high, shifting stops and the word is copied into a holding latch. Only the latch drives the outputs.

The latched word is decoded into a signed offset from -15 to +15, a raw magnitude and direction, and a test-mode flag. The three asynchronous inputs (shift clock, serial data and enable) are synchronized into the system clock. All edge detection happens in that domain. The enable should be held low through reset. Tying the serial data input low and then raising the enable therefore loads the nominal, zero-offset setting.

Top module: `strobe_ctrl_reg`

## Requirements
- R1: During and after reset, before any load, the magnitude, direction, test flag, signed offset and update pulse outputs are all zero.
- R2: The serial word is MSB first. The first bit shifted in ends up as bit 5 of the latched word and the last one as bit 0.
- R3: Bits 3..0 of the latched word appear on the magnitude output. Bit 4 appears on the direction output, where 1 means late (positive) and 0 means early (negative). Bit 5 appears on the test flag.
- R4: With test mode off, the signed output is the 5-bit two's-complement value +magnitude when bit 4 is 1 and -magnitude when bit 4 is 0. Both 00000 and 10000 give 0.
- R5: When bit 5 is 1, the test flag is 1 and the signed output is forced to 0.
- R6: While the enable is low, shifting new bits leaves every latched output unchanged.
- R7: Shift clock edges that arrive while the enable is high do not enter the shift register. The next enable rise then latches the earlier word again.
- R8: Each rising edge of the enable produces exactly one single-cycle update pulse, and the latched outputs change only in that same cycle.
- R9: When more than six bits are shifted before a load, only the last six bits are kept.
- R10: Shifting six zeros and then raising the enable loads the nominal setting: signed output 0, test flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_clk_i | input | 1 | Asynchronous serial shift clock; data is taken on its rising edge |
| shift_dat_i | input | 1 | Serial data, MSB first |
| lock_i | input | 1 | Low: shifting allowed. A rising edge copies the shift word into the latch |
| strobe_mag_o | output | 4 | Latched magnitude field |
| strobe_late_o | output | 1 | Latched direction (1 = late) |
| test_mode_o | output | 1 | Latched test bit |
| strobe_val_o | output | 5 | Signed two's-complement offset |
| update_o | output | 1 | One-cycle pulse when the latch takes a new word |

## Verification
The assertions check four things on every cycle: the update pulse lasts exactly one cycle and follows a detected enable rise, the latched fields change only together with the update pulse, the shift register is frozen while the synchronized enable is high, and the signed offset agrees in sign and zero with the latched fields and is forced to zero in test mode. The bench scenarios cover what depends on complete serial sequences: the MSB-first bit order, keeping only the last six bits of an overlong stream, reloading a stale word after shift edges that were ignored, and the exact decoded value for each word.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  parameter int MAG_W  = 4;
  parameter int WORD_W = MAG_W + 2;
  parameter int VAL_W  = MAG_W + 1;

  typedef struct packed {
    logic             test;
    logic             late;
    logic [MAG_W-1:0] mag;
  } strobe_word_t;

  function automatic strobe_word_t to_word(input logic [WORD_W-1:0] raw);
    strobe_word_t w;
    w.test = raw[WORD_W-1];
    w.late = raw[WORD_W-2];
    w.mag  = raw[MAG_W-1:0];
    return w;
  endfunction

  function automatic logic signed [VAL_W-1:0] offset_of(input strobe_word_t w);
    logic signed [VAL_W-1:0] m;
    m = signed'({1'b0, w.mag});
    if (w.test) return '0;
    return w.late ? m : -m;
  endfunction

endpackage

// File: rtl/strobe_sync_bus.sv
module strobe_sync_bus #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/strobe_shifter.sv
module strobe_shifter #(
  parameter int WORD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              lock_i,
  output logic              step_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_prev_q;
  logic [WORD_W-1:0] shift_q;

  assign step_o = sclk_i & ~sclk_prev_q & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      shift_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (step_o) shift_q <= {shift_q[WORD_W-2:0], sdat_i};
    end
  end

  assign word_o = shift_q;
endmodule

// File: rtl/strobe_latch.sv
module strobe_latch
  import strobe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic [WORD_W-1:0] shift_word_i,
  output logic              rise_o,
  output strobe_word_t      held_o,
  output logic              update_o
);
  logic         lock_prev_q;
  logic         upd_q;
  strobe_word_t held_q;

  assign rise_o = lock_i & ~lock_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_prev_q <= 1'b0;
      upd_q       <= 1'b0;
      held_q      <= '0;
    end else begin
      lock_prev_q <= lock_i;
      upd_q       <= rise_o;
      if (rise_o) held_q <= to_word(shift_word_i);
    end
  end

  assign held_o   = held_q;
  assign update_o = upd_q;
endmodule

// File: rtl/strobe_ctrl_reg.sv
module strobe_ctrl_reg
  import strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_clk_i,
  input  logic                    shift_dat_i,
  input  logic                    lock_i,
  output logic [MAG_W-1:0]        strobe_mag_o,
  output logic                    strobe_late_o,
  output logic                    test_mode_o,
  output logic signed [VAL_W-1:0] strobe_val_o,
  output logic                    update_o
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] sync_w;
  logic              sclk_w, sdat_w, lock_lvl_w;
  logic              shift_step_w, lock_rise_w;
  logic [WORD_W-1:0] shift_word_w;
  strobe_word_t      held_w;

  strobe_sync_bus #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({lock_i, shift_dat_i, shift_clk_i}),
    .sync_o  (sync_w)
  );

  assign sclk_w     = sync_w[0];
  assign sdat_w     = sync_w[1];
  assign lock_lvl_w = sync_w[2];

  strobe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_w),
    .sdat_i (sdat_w),
    .lock_i (lock_lvl_w),
    .step_o (shift_step_w),
    .word_o (shift_word_w)
  );

  strobe_latch u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock_lvl_w),
    .shift_word_i (shift_word_w),
    .rise_o       (lock_rise_w),
    .held_o       (held_w),
    .update_o     (update_o)
  );

  assign strobe_mag_o  = held_w.mag;
  assign strobe_late_o = held_w.late;
  assign test_mode_o   = held_w.test;
  assign strobe_val_o  = offset_of(held_w);
endmodule

// File: rtl/strobe_ctrl_chk.sv
module strobe_ctrl_chk
  import strobe_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    lock_lvl_i,
  input logic                    lock_rise_i,
  input logic                    shift_step_i,
  input logic [WORD_W-1:0]       shift_word_i,
  input logic [MAG_W-1:0]        mag_i,
  input logic                    late_i,
  input logic                    test_i,
  input logic signed [VAL_W-1:0] val_i,
  input logic                    update_i
);
  assert_upd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> !update_i);

  assert_upd_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rise_i |=> update_i);

  assert_latch_only_on_upd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({test_i, late_i, mag_i}) |-> update_i);

  assert_frozen_when_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lvl_i |=> $stable(shift_word_i));

  assert_no_step_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lvl_i |-> !shift_step_i);

  assert_test_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> (val_i == '0));

  assert_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && mag_i != '0) |-> (val_i[VAL_W-1] == !late_i));

  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i == '0) |-> (val_i == '0));
endmodule

bind strobe_ctrl_reg strobe_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lock_lvl_i   (lock_lvl_w),
  .lock_rise_i  (lock_rise_w),
  .shift_step_i (shift_step_w),
  .shift_word_i (shift_word_w),
  .mag_i        (strobe_mag_o),
  .late_i       (strobe_late_o),
  .test_i       (test_mode_o),
  .val_i        (strobe_val_o),
  .update_i     (update_o)
);

// File: tb/test_strobe_ctrl_reg.sv
module test_strobe_ctrl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, lock = 1'b0;
  logic [3:0] mag;
  logic late, tst, upd;
  logic signed [4:0] val;

  int n_checks = 0, n_errors = 0, upd_count = 0, upd_run = 0, upd_maxrun = 0;
  bit done = 0;
  logic [5:0] last_word = '0;

  always #2.5 clk = ~clk;

  strobe_ctrl_reg i_strobe_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .shift_clk_i(sclk), .shift_dat_i(sdat),
    .lock_i(lock), .strobe_mag_o(mag), .strobe_late_o(late),
    .test_mode_o(tst), .strobe_val_o(val), .update_o(upd)
  );

  always @(negedge clk) begin
    if (upd) begin upd_count++; upd_run++; if (upd_run > upd_maxrun) upd_maxrun = upd_run; end
    else upd_run = 0;
  end

  function automatic int exp_val(input logic [5:0] w);
    int m = int'(w[3:0]);
    if (w[5]) return 0;
    return w[4] ? m : -m;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b; wait_cyc(4);
    sclk = 1'b1; wait_cyc(4);
    sclk = 1'b0; wait_cyc(4);
  endtask

  task automatic load(input logic [5:0] w, input int extra, input logic [3:0] junk);
    lock = 1'b0; wait_cyc(6);
    for (int i = extra - 1; i >= 0; i--) send_bit(junk[i]);
    for (int i = 5; i >= 0; i--) send_bit(w[i]);
    upd_count = 0; upd_maxrun = 0;
    lock = 1'b1; wait_cyc(10);
    last_word = w;
  endtask

  task automatic check_word(input string req, input logic [5:0] w);
    check({req, " mag"},  int'(mag), int'(w[3:0]));
    check({req, " late"}, int'(late), int'(w[4]));
    check({req, " test"}, int'(tst), int'(w[5]));
    check({req, " val"},  int'(val), exp_val(w));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(5);
    // R1 reset state
    check("R1 val", int'(val), 0); check("R1 mag", int'(mag), 0);
    check("R1 upd", int'(upd), 0); check("R1 test", int'(tst), 0);
    rst_n = 1'b1; wait_cyc(5);
    check("R1 after release", int'({tst, late, mag, upd}), 0);

    // R2/R3 bit order and fields: late +5 = 010101
    load(6'b010101, 0, 4'h0);
    check_word("R2 R3", 6'b010101);
    check("R4 +5", int'(val), 5);
    check("R8 one pulse", upd_count, 1);
    check("R8 width", upd_maxrun, 1);
    // R4 early -15 and +15, both zeros
    load(6'b001111, 0, 4'h0); check("R4 -15", int'(val), -15);
    load(6'b011111, 0, 4'h0); check("R4 +15", int'(val), 15);
    load(6'b010000, 0, 4'h0); check("R4 zero late code", int'(val), 0);
    load(6'b000000, 0, 4'h0); check_word("R10 nominal", 6'b000000);
    // R5 test mode
    load(6'b101011, 0, 4'h0);
    check("R5 flag", int'(tst), 1); check("R5 val", int'(val), 0);

    // R6: shifting with lock low does not touch outputs
    load(6'b011001, 0, 4'h0);
    lock = 1'b0; wait_cyc(6);
    upd_count = 0;
    for (int i = 5; i >= 0; i--) send_bit(1'b1);
    check_word("R6 held", 6'b011001);
    check("R6 no pulse", upd_count, 0);
    lock = 1'b1; wait_cyc(10);
    check_word("R6 then load", 6'b111111);

    // R7: edges while locked are ignored
    load(6'b000110, 0, 4'h0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    lock = 1'b0; wait_cyc(8);
    upd_count = 0;
    lock = 1'b1; wait_cyc(10);
    check_word("R7 stale reload", 6'b000110);
    check("R7 pulse", upd_count, 1);

    // R9: overlong stream keeps last six
    load(6'b010011, 4, 4'b1101);
    check_word("R9 last six", 6'b010011);

    // randomized loads
    for (int k = 0; k < 40; k++) begin
      logic [5:0] w;
      int ex;
      w = 6'($urandom);
      if ($urandom_range(3) != 0) w[5] = 1'b0;
      ex = $urandom_range(3);
      load(w, ex, 4'($urandom));
      check_word("R4 R9 random", w);
      check("R8 random pulse", upd_count, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule